// File: doc/BRIEF.md
# Low-Power Mode State Controller

This block sequences a processor subsystem through four power modes: normal-high, normal-low, doze-high and doze-low. Software asks for doze by writing the doze code into a two-bit mode field and raising the core power-down request. A clock-source select bit picks which of the two doze modes is entered. While dozing, the block chooses the doze divider that the clock generator applies. It leaves doze when an enabled interrupt is pending or when the decrementer fires.

On the way out of doze the block pulses a strobe. The strobe tells the register that holds the mode field to return it to zero. The block also reports whether the core should vector to the external interrupt handler or continue inline after the instruction that entered low power.

In doze-low, coprocessor activity can lift the block into a temporary doze-high state when that wake path is enabled. The block drops back to doze-low by itself once the coprocessor goes idle. This temporary state is kept apart from a doze-high state that software entered, because only the temporary state returns to doze-low.

Top module: `lowpwr_mode_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the block in normal-high, with `mode`=00, `div_sel`=00, `lpm_clr`=0 and `resume_vec`=0. A reset taken while dozing does the same.
- R2: In a normal mode, doze is entered on the next clock edge only when `lpm_field`=01, `pwr_down_req`=1 and `tmr_nest`=0. `clk_src_sel`=0 selects doze-high and 1 selects doze-low. Any other field value, or `pwr_down_req`=0, leaves the mode unchanged.
- R3: While `tmr_nest`=1, a doze request is ignored and the block stays in its normal mode.
- R4: `div_sel` is 01 (high-mode doze divider) in doze-high, including the temporary state. It is 10 (low-mode doze divider) in doze-low and 00 in either normal mode. `mode` encodes normal-high=00, normal-low=01, doze-high=10 and doze-low=11.
- R5: A pending interrupt (`irq_pending`=1) wakes the block only when `irq_wake_en`=1. With the enable clear, the block stays in doze.
- R6: A wake from doze-high entered by software moves the block to normal-high.
- R7: A wake from doze-low, or from the temporary doze-high state, moves the block to normal-high when `irq_wake_en`=1 and to normal-low otherwise. `dec_wake`=1 wakes the block whatever the state of `irq_wake_en`.
- R8: `lpm_clr` is high for exactly one cycle: the first cycle of the normal mode entered from doze.
- R9: `resume_vec` is updated on each wake and holds its value until the next wake. It is 1 (jump to the interrupt vector) when an enabled pending interrupt caused the wake. It is 0 (continue inline) when only the decrementer did.
- R10: In doze-low, `cop_wake_en`=1 with `cop_busy`=1 moves the block to the temporary doze-high state, which it leaves for doze-low once `cop_busy` falls. With `cop_wake_en`=0, coprocessor activity has no effect.
- R11: Doze-high entered by software does not react to coprocessor activity, and does not fall to doze-low when `cop_busy` falls.
- R12: If a wake and coprocessor activity arrive in the same cycle in doze-low, the wake wins and the block enters a normal mode.
- R13: While dozing, a new doze request on `lpm_field`, `pwr_down_req` or `clk_src_sel` has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lpm_field | input | 2 | Low-power-mode field; 01 requests doze |
| clk_src_sel | input | 1 | Doze flavour select: 0 doze-high, 1 doze-low |
| pwr_down_req | input | 1 | Core power-down request |
| tmr_nest | input | 1 | Timer-interrupt-nesting status; blocks doze entry when set |
| irq_wake_en | input | 1 | Enables wake on pending interrupts |
| cop_wake_en | input | 1 | Enables the temporary doze-high state for coprocessor activity |
| irq_pending | input | 1 | An enabled interrupt is pending |
| dec_wake | input | 1 | Decrementer wake event |
| cop_busy | input | 1 | Coprocessor is servicing a request |
| mode | output | 2 | Current mode code |
| div_sel | output | 2 | Doze divider select: 00 none, 01 high-mode, 10 low-mode |
| lpm_clr | output | 1 | One-cycle strobe that clears the mode field |
| resume_vec | output | 1 | 1 = vector to the interrupt handler, 0 = continue inline |

## Verification
The embedded properties check, on every cycle, that the clear strobe never lasts more than one cycle. They also check that a blocked or absent request keeps a normal mode and that dozing persists without an enabled wake. Further properties cover the temporary state returning to doze-low when the coprocessor idles, software doze-high staying put, and a wake beating coprocessor activity. Only the bench scenarios show the exit targets chosen by the enable bit and the vector-versus-inline decision for decrementer and interrupt wakes. They also show the divider codes for each mode and a reset taken in the middle of a doze.

// File: rtl/lpm_ctrl_pkg.sv
// Package: shared state and output encodings for the low-power mode controller.
// Assumes: mode and divider codes are decoded by neighbouring clock logic.
package lpm_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_NRM_HI  = 3'd0,
        ST_NRM_LO  = 3'd1,
        ST_DZ_HI   = 3'd2,   // doze-high requested by software
        ST_DZ_LO   = 3'd3,
        ST_DZ_TMP  = 3'd4    // doze-high borrowed for coprocessor service
    } pm_state_e;

    localparam logic [1:0] MODE_NRM_HI = 2'b00;
    localparam logic [1:0] MODE_NRM_LO = 2'b01;
    localparam logic [1:0] MODE_DZ_HI  = 2'b10;
    localparam logic [1:0] MODE_DZ_LO  = 2'b11;

    localparam logic [1:0] DIV_NONE = 2'b00;
    localparam logic [1:0] DIV_HIGH = 2'b01;
    localparam logic [1:0] DIV_LOW  = 2'b10;

endpackage

// File: rtl/lpm_wake_eval.sv
// Module: lpm_wake_eval
// Purpose: combinational qualification of doze requests and wake events.
// Assumes: all inputs are synchronous to the controller clock.
module lpm_wake_eval #(
    parameter int               LPM_W     = 2,
    parameter logic [LPM_W-1:0] DOZE_CODE = 1
) (
    input  logic [LPM_W-1:0] lpm_field,
    input  logic             pwr_down_req,
    input  logic             tmr_nest,
    input  logic             irq_pending,
    input  logic             irq_wake_en,
    input  logic             dec_wake,
    output logic             doze_req,
    output logic             wake,
    output logic             wake_vec,
    output logic             exit_low
);

    logic irq_wake;

    // Qualify the doze request and classify the wake source.
    always_comb begin
        doze_req = (lpm_field == DOZE_CODE) && pwr_down_req && !tmr_nest;
        irq_wake = irq_pending && irq_wake_en;
        wake     = irq_wake || dec_wake;
        wake_vec = irq_wake;
        exit_low = !irq_wake_en;
    end

endmodule

// File: rtl/lpm_mode_fsm.sv
// Module: lpm_mode_fsm
// Purpose: mode state register, exit strobe and resume-type register.
// Assumes: wake/doze_req are already qualified by lpm_wake_eval.
module lpm_mode_fsm
    import lpm_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      doze_req,
    input  logic      clk_src_sel,
    input  logic      wake,
    input  logic      wake_vec,
    input  logic      exit_low,
    input  logic      cop_wake_en,
    input  logic      cop_busy,
    output pm_state_e state_q,
    output logic      lpm_clr,
    output logic      resume_vec
);

    pm_state_e state_d;
    logic      in_doze;
    logic      leave_doze;

    // Next-state selection; a wake outranks coprocessor activity.
    always_comb begin
        state_d = state_q;
        in_doze = (state_q == ST_DZ_HI) || (state_q == ST_DZ_LO) ||
                  (state_q == ST_DZ_TMP);
        leave_doze = in_doze && wake;
        case (state_q)
            ST_NRM_HI, ST_NRM_LO: begin
                if (doze_req)
                    state_d = clk_src_sel ? ST_DZ_LO : ST_DZ_HI;
            end
            ST_DZ_HI: begin
                if (wake)
                    state_d = ST_NRM_HI;
            end
            ST_DZ_LO: begin
                if (wake)
                    state_d = exit_low ? ST_NRM_LO : ST_NRM_HI;
                else if (cop_wake_en && cop_busy)
                    state_d = ST_DZ_TMP;
            end
            ST_DZ_TMP: begin
                if (wake)
                    state_d = exit_low ? ST_NRM_LO : ST_NRM_HI;
                else if (!cop_busy)
                    state_d = ST_DZ_LO;
            end
            default: state_d = ST_NRM_HI;
        endcase
    end

    // State, clear strobe and resume type, with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_NRM_HI;
            lpm_clr    <= 1'b0;
            resume_vec <= 1'b0;
        end else begin
            state_q <= state_d;
            lpm_clr <= leave_doze;
            if (leave_doze)
                resume_vec <= wake_vec;
        end
    end

    // R8: the clear strobe never lasts two cycles.
    p_clr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_clr |=> !lpm_clr);

    // R3, R2: without a qualified request a normal mode is kept.
    p_stay_normal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_NRM_HI || state_q == ST_NRM_LO) && !doze_req)
        |=> (state_q == $past(state_q)));

    // R10: the borrowed doze-high returns to doze-low when the coprocessor idles.
    p_tmp_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DZ_TMP && !wake && !cop_busy) |=> (state_q == ST_DZ_LO));

    // R11: software doze-high only leaves on a wake.
    p_sw_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DZ_HI && !wake) |=> (state_q == ST_DZ_HI));

    // R12: a wake beats coprocessor activity in the same cycle.
    p_wake_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DZ_LO && wake && cop_busy && cop_wake_en)
        |=> (state_q == ST_NRM_HI || state_q == ST_NRM_LO));

endmodule

// File: rtl/lpm_out_decode.sv
// Module: lpm_out_decode
// Purpose: map the internal state onto the mode code and divider select.
// Assumes: the borrowed doze-high state reports as plain doze-high.
module lpm_out_decode
    import lpm_ctrl_pkg::*;
(
    input  pm_state_e  state_q,
    output logic [1:0] mode,
    output logic [1:0] div_sel
);

    // Translate state into externally visible codes.
    always_comb begin
        case (state_q)
            ST_NRM_LO: begin mode = MODE_NRM_LO; div_sel = DIV_NONE; end
            ST_DZ_HI:  begin mode = MODE_DZ_HI;  div_sel = DIV_HIGH; end
            ST_DZ_TMP: begin mode = MODE_DZ_HI;  div_sel = DIV_HIGH; end
            ST_DZ_LO:  begin mode = MODE_DZ_LO;  div_sel = DIV_LOW;  end
            default:   begin mode = MODE_NRM_HI; div_sel = DIV_NONE; end
        endcase
    end

endmodule

// File: rtl/lowpwr_mode_ctrl.sv
// Module: lowpwr_mode_ctrl (top)
// Purpose: four-mode power sequencer with a borrowed doze-high for coprocessor work.
// Assumes: synchronous inputs; the mode field register honours lpm_clr.
module lowpwr_mode_ctrl
    import lpm_ctrl_pkg::*;
#(
    parameter int               LPM_W     = 2,
    parameter logic [LPM_W-1:0] DOZE_CODE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LPM_W-1:0] lpm_field,
    input  logic             clk_src_sel,
    input  logic             pwr_down_req,
    input  logic             tmr_nest,
    input  logic             irq_wake_en,
    input  logic             cop_wake_en,
    input  logic             irq_pending,
    input  logic             dec_wake,
    input  logic             cop_busy,
    output logic [1:0]       mode,
    output logic [1:0]       div_sel,
    output logic             lpm_clr,
    output logic             resume_vec
);

    logic      doze_req;
    logic      wake;
    logic      wake_vec;
    logic      exit_low;
    pm_state_e state_q;

    lpm_wake_eval #(.LPM_W(LPM_W), .DOZE_CODE(DOZE_CODE)) u_eval (
        .lpm_field    (lpm_field),
        .pwr_down_req (pwr_down_req),
        .tmr_nest     (tmr_nest),
        .irq_pending  (irq_pending),
        .irq_wake_en  (irq_wake_en),
        .dec_wake     (dec_wake),
        .doze_req     (doze_req),
        .wake         (wake),
        .wake_vec     (wake_vec),
        .exit_low     (exit_low)
    );

    lpm_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .doze_req    (doze_req),
        .clk_src_sel (clk_src_sel),
        .wake        (wake),
        .wake_vec    (wake_vec),
        .exit_low    (exit_low),
        .cop_wake_en (cop_wake_en),
        .cop_busy    (cop_busy),
        .state_q     (state_q),
        .lpm_clr     (lpm_clr),
        .resume_vec  (resume_vec)
    );

    lpm_out_decode u_dec (
        .state_q (state_q),
        .mode    (mode),
        .div_sel (div_sel)
    );

    // R5: a pending interrupt with its enable clear keeps the block dozing.
    p_no_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && irq_pending && !irq_wake_en && !dec_wake) |=> mode[1]);

    // R4: a normal mode never carries a doze divider.
    p_div_normal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |-> (div_sel == 2'b00));

endmodule

// File: tb/lowpwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module lowpwr_mode_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] lpm_field = '0;
    logic       clk_src_sel = 1'b0, pwr_down_req = 1'b0, tmr_nest = 1'b0;
    logic       irq_wake_en = 1'b0, cop_wake_en = 1'b0;
    logic       irq_pending = 1'b0, dec_wake = 1'b0, cop_busy = 1'b0;
    logic [1:0] mode, div_sel;
    logic       lpm_clr, resume_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lowpwr_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .lpm_field(lpm_field), .clk_src_sel(clk_src_sel),
        .pwr_down_req(pwr_down_req), .tmr_nest(tmr_nest), .irq_wake_en(irq_wake_en),
        .cop_wake_en(cop_wake_en), .irq_pending(irq_pending), .dec_wake(dec_wake),
        .cop_busy(cop_busy), .mode(mode), .div_sel(div_sel), .lpm_clr(lpm_clr),
        .resume_vec(resume_vec)
    );

    // Row: [15:14] field, 13 csel, 12 pdr, 11 tmr, 10 iwe, 9 cwe, 8 irq, 7 dec,
    //      6 cop, [5:4] mode, [3:2] div_sel, 1 clr, 0 vec (expected after one edge)
    localparam int NV = 23;
    localparam logic [15:0] VEC [NV] = '{
        16'b01_0_1_1_0_0_0_0_0_00_00_0_0, // 0  R3 blocked by nesting bit
        16'b10_0_1_0_0_0_0_0_0_00_00_0_0, // 1  R2 wrong field code
        16'b01_0_0_0_0_0_0_0_0_00_00_0_0, // 2  R2 no power-down request
        16'b01_0_1_0_0_0_0_0_0_10_01_0_0, // 3  R2 R4 enter doze-high
        16'b00_0_0_0_0_0_1_0_0_10_01_0_0, // 4  R5 irq without enable
        16'b00_0_0_0_0_1_0_0_1_10_01_0_0, // 5  R11 coprocessor ignored
        16'b01_1_1_0_0_0_0_0_0_10_01_0_0, // 6  R13 request while dozing
        16'b00_0_0_0_1_0_1_0_0_00_00_1_1, // 7  R6 R8 R9 irq wake
        16'b00_0_0_0_0_0_0_0_0_00_00_0_1, // 8  R8 strobe ends
        16'b01_1_1_0_0_0_0_0_0_11_10_0_1, // 9  R2 R4 enter doze-low
        16'b00_0_0_0_0_0_0_0_1_11_10_0_1, // 10 R10 coprocessor, enable clear
        16'b00_0_0_0_0_1_0_0_1_10_01_0_1, // 11 R10 borrowed doze-high
        16'b00_0_0_0_0_1_0_0_1_10_01_0_1, // 12 R10 stays while busy
        16'b00_0_0_0_0_1_0_0_0_11_10_0_1, // 13 R10 back to doze-low
        16'b00_0_0_0_0_0_0_1_0_01_00_1_0, // 14 R7 R9 decrementer to normal-low
        16'b00_0_0_0_0_0_0_0_0_01_00_0_0, // 15 R8 strobe ends
        16'b01_1_1_0_0_0_0_0_0_11_10_0_0, // 16 R2 doze-low from normal-low
        16'b00_0_0_0_1_1_1_0_1_00_00_1_1, // 17 R12 wake beats coprocessor
        16'b00_0_0_0_0_0_0_0_0_00_00_0_1, // 18 R8 idle
        16'b01_1_1_0_0_0_0_0_0_11_10_0_1, // 19 R2 doze-low again
        16'b00_0_0_0_1_0_0_1_0_00_00_1_0, // 20 R7 R9 decrementer, enable set
        16'b01_0_1_0_0_0_0_0_0_10_01_0_0, // 21 R2 doze-high again
        16'b00_0_0_0_0_0_0_1_0_00_00_1_0  // 22 R7 decrementer ungated
    };

    function automatic string row_req(int i);
        case (i)
            0: return "R3";
            1, 2, 9, 16, 19, 21: return "R2";
            3: return "R4";
            4: return "R5";
            5: return "R11";
            6: return "R13";
            7: return "R6";
            8, 15, 18: return "R8";
            10, 11, 12, 13: return "R10";
            14, 20, 22: return "R7";
            17: return "R12";
            default: return "R9";
        endcase
    endfunction

    task automatic check6(string req, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {mode,div,clr,vec} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(logic [9:0] v);
        {lpm_field, clk_src_sel, pwr_down_req, tmr_nest, irq_wake_en,
         cop_wake_en, irq_pending, dec_wake, cop_busy} = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check6("R1", {mode, div_sel, lpm_clr, resume_vec}, 6'b00_00_0_0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][15:6]);
            @(negedge clk);
            check6(row_req(i), {mode, div_sel, lpm_clr, resume_vec}, VEC[i][5:0]);
        end

        // R9: resume type held through an idle cycle after inline wake
        drive(10'b0);
        @(negedge clk);
        check6("R9", {mode, div_sel, lpm_clr, resume_vec}, 6'b00_00_0_0);

        // R1: reset taken in the middle of doze-low after an interrupt wake history
        drive(10'b00_0_0_0_1_0_1_0_0);   // irq wake not applicable in normal: no change
        @(negedge clk);
        drive(10'b01_1_1_0_0_0_0_0_0);
        @(negedge clk);
        check6("R2", {mode, div_sel, lpm_clr, resume_vec}, 6'b11_10_0_0);
        drive(10'b00_0_0_0_1_0_1_0_0);   // wake to set vector flag
        @(negedge clk);
        check6("R9", {mode, div_sel, lpm_clr, resume_vec}, 6'b00_00_1_1);
        drive(10'b01_1_1_0_0_0_0_0_0);
        @(negedge clk);
        drive(10'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check6("R1", {mode, div_sel, lpm_clr, resume_vec}, 6'b00_00_0_0);
        rst_n = 1'b1;
        @(negedge clk);
        check6("R1", {mode, div_sel, lpm_clr, resume_vec}, 6'b00_00_0_0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule